// File: doc/BRIEF.md
# Programmable AND-Plane Product Term Generator

This block forms the AND half of a sum-of-products logic array. Sixteen input signals are each offered to the plane twice, once as is and once inverted, which gives 32 columns. Each of the 64 product terms picks any subset of those columns through a row of connect bits held in a small map store. Because both polarities of every signal are available, a term can require a signal to be high, to be low, or ignore it. The 64 term values leave the block grouped for a following OR stage, eight consecutive terms per OR group: terms 8g to 8g+7 form group g.

The map is loaded one row per clock through a plain address and data port. Each row carries 32 connect bits and a separate enable bit that marks the term as in use. A term whose enable bit is clear is held at LOW, so it never toggles and adds nothing to its OR group. The enable bits are also reported on a port. The term outputs are combinational from the inputs and the stored map, with no register on the evaluation path.

Top module: `pt_and_plane`

## Requirements
- R1: A synchronous active-high reset clears every connect bit and every enable bit; after the reset edge `term_used` and `term_out` are all zero whatever `sig_in` holds.
- R2: Input bit i drives column 2i in true form and column 2i+1 in inverted form; connect bit c of a row refers to column c.
- R3: An enabled term is HIGH exactly when every column it connects to is HIGH.
- R4: An enabled term with no connect bits set is HIGH for every input pattern.
- R5: An enabled term connected to both columns 2i and 2i+1 of the same input is LOW for every input pattern.
- R6: A term whose enable bit is clear outputs LOW regardless of its connect bits and the inputs, and its bit of `term_used` reads 0; a set enable bit reads 1.
- R7: With `wr_en` high at a rising clock edge, the row at `wr_addr` takes `wr_conn` and `wr_used`; the outputs show the new row right after that edge and not before, and all other rows keep their contents.
- R8: A change on `sig_in` reaches `term_out` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the map store |
| rst | input | 1 | Synchronous active-high reset, clears the map |
| sig_in | input | 16 | Array input signals |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 6 | Term index of the row to write |
| wr_conn | input | 32 | Connect bits of the row, bit c selects column c |
| wr_used | input | 1 | Enable bit of the row |
| term_out | output | 64 | Product term values, bit t is term t |
| term_used | output | 64 | Enable bit of each term |

## Verification
The bench builds the block with its default parameters: 16 signals, 64 terms and groups of eight. That puts the last term address 63, the first and last columns of the plane, and the boundaries between OR groups within reach of directed writes, while random input patterns exercise rows that mix true and inverted columns across several groups.

// File: rtl/pt_plane_pkg.sv
package pt_plane_pkg;

    localparam int unsigned DEF_SIGNALS   = 16;
    localparam int unsigned DEF_TERMS     = 64;
    localparam int unsigned DEF_GROUP_LEN = 8;

    // Polarity of a column relative to its source signal
    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } col_pol_e;

    // Column position of a signal in a given polarity
    function automatic int unsigned col_index(int unsigned sig, col_pol_e pol);
        return 2 * sig + ((pol == POL_COMP) ? 1 : 0);
    endfunction

endpackage

// File: rtl/pt_col_drive.sv
module pt_col_drive
    import pt_plane_pkg::*;
#(
    parameter int unsigned N_SIGNALS = DEF_SIGNALS,
    localparam int unsigned N_COLS   = 2 * N_SIGNALS
) (
    input  logic [N_SIGNALS-1:0] sig_in,
    output logic [N_COLS-1:0]    cols
);

    for (genvar i = 0; i < N_SIGNALS; i++) begin : g_sig
        localparam int unsigned TRUE_COL = col_index(i, POL_TRUE);
        localparam int unsigned COMP_COL = col_index(i, POL_COMP);
        assign cols[TRUE_COL] = sig_in[i];
        assign cols[COMP_COL] = ~sig_in[i];
    end

endmodule

// File: rtl/pt_map_store.sv
module pt_map_store #(
    parameter int unsigned N_COLS  = 32,
    parameter int unsigned N_TERMS = 64,
    localparam int unsigned ADDR_W = $clog2(N_TERMS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [N_COLS-1:0]              wr_conn,
    input  logic                           wr_used,
    output logic [N_TERMS-1:0][N_COLS-1:0] conn_q,
    output logic [N_TERMS-1:0]             used_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q <= '0;
            used_q <= '0;
        end else if (wr_en) begin
            conn_q[wr_addr] <= wr_conn;
            used_q[wr_addr] <= wr_used;
        end
    end

    // R1
    map_cleared_chk: assert property (@(posedge clk)
        rst |=> (used_q == '0) && (conn_q == '0));

    // R7
    row_written_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (conn_q[$past(wr_addr)] == $past(wr_conn))
               && (used_q[$past(wr_addr)] == $past(wr_used)));

    // R7
    map_held_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(conn_q) && $stable(used_q));

endmodule

// File: rtl/pt_term_eval.sv
module pt_term_eval #(
    parameter int unsigned N_COLS    = 32,
    parameter int unsigned N_TERMS   = 64,
    parameter int unsigned GROUP_LEN = 8,
    localparam int unsigned N_GROUPS = N_TERMS / GROUP_LEN,
    localparam int unsigned N_PAIRS  = N_COLS / 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [N_COLS-1:0]              cols,
    input  logic [N_TERMS-1:0][N_COLS-1:0] conn,
    input  logic [N_TERMS-1:0]             used,
    output logic [N_TERMS-1:0]             term_out
);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        for (genvar m = 0; m < GROUP_LEN; m++) begin : g_term
            localparam int unsigned T = g * GROUP_LEN + m;
            logic [N_COLS-1:0] miss;
            logic [N_PAIRS-1:0] clash;

            // A connected column that is LOW blocks the term
            assign miss        = conn[T] & ~cols;
            assign term_out[T] = used[T] & ~(|miss);

            for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
                assign clash[p] = conn[T][2*p] & conn[T][2*p+1];
            end

            // R4
            empty_high_chk: assert property (@(posedge clk) disable iff (rst)
                (used[T] && conn[T] == '0) |-> term_out[T]);

            // R5
            clash_low_chk: assert property (@(posedge clk) disable iff (rst)
                (|clash) |-> !term_out[T]);

            // R6
            idle_low_chk: assert property (@(posedge clk) disable iff (rst)
                !used[T] |-> !term_out[T]);
        end
    end

endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane
    import pt_plane_pkg::*;
#(
    parameter int unsigned N_SIGNALS = DEF_SIGNALS,
    parameter int unsigned N_TERMS   = DEF_TERMS,
    parameter int unsigned GROUP_LEN = DEF_GROUP_LEN,
    localparam int unsigned N_COLS   = 2 * N_SIGNALS,
    localparam int unsigned ADDR_W   = $clog2(N_TERMS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SIGNALS-1:0] sig_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [N_COLS-1:0]    wr_conn,
    input  logic                 wr_used,
    output logic [N_TERMS-1:0]   term_out,
    output logic [N_TERMS-1:0]   term_used
);

    logic [N_COLS-1:0]              cols;
    logic [N_TERMS-1:0][N_COLS-1:0] conn_q;
    logic [N_TERMS-1:0]             used_q;

    pt_col_drive #(
        .N_SIGNALS (N_SIGNALS)
    ) u_cols (
        .sig_in (sig_in),
        .cols   (cols)
    );

    pt_map_store #(
        .N_COLS  (N_COLS),
        .N_TERMS (N_TERMS)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_conn (wr_conn),
        .wr_used (wr_used),
        .conn_q  (conn_q),
        .used_q  (used_q)
    );

    pt_term_eval #(
        .N_COLS    (N_COLS),
        .N_TERMS   (N_TERMS),
        .GROUP_LEN (GROUP_LEN)
    ) u_eval (
        .clk      (clk),
        .rst      (rst),
        .cols     (cols),
        .conn     (conn_q),
        .used     (used_q),
        .term_out (term_out)
    );

    assign term_used = used_q;

    // R6
    out_within_used_chk: assert property (@(posedge clk) disable iff (rst)
        (term_out & ~term_used) == '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (term_out == '0) && (term_used == '0));

    // R7
    used_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> term_used[$past(wr_addr)] == $past(wr_used));

endmodule

// File: tb/pt_and_plane_tb.sv
module pt_and_plane_tb;

    localparam int NS = 16;
    localparam int NT = 64;
    localparam int NC = 2 * NS;

    typedef struct {
        logic [NT-1:0] out_exp;
        logic [NT-1:0] used_exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] sig_in = '0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [NC-1:0] wr_conn = '0;
    logic          wr_used = 1'b0;
    logic [NT-1:0] term_out;
    logic [NT-1:0] term_used;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NC-1:0] m_conn [NT];
    logic          m_used [NT];
    item_t         sb_q[$];
    event          item_ev;

    always #2.5 clk = ~clk;

    pt_and_plane u_dut (
        .clk       (clk),
        .rst       (rst),
        .sig_in    (sig_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_conn   (wr_conn),
        .wr_used   (wr_used),
        .term_out  (term_out),
        .term_used (term_used)
    );

    // Expected value built from the rules: column 2i = sig i, 2i+1 = ~sig i
    function automatic logic [NT-1:0] model_out(logic [NS-1:0] s);
        logic [NT-1:0] r;
        for (int t = 0; t < NT; t++) begin
            logic v;
            v = m_used[t];
            for (int c = 0; c < NC; c++) begin
                logic colv;
                colv = (c % 2 == 0) ? s[c/2] : !s[c/2];
                if (m_conn[t][c] && !colv) v = 1'b0;
            end
            r[t] = v;
        end
        return r;
    endfunction

    function automatic logic [NT-1:0] model_used();
        logic [NT-1:0] r;
        for (int t = 0; t < NT; t++) r[t] = m_used[t];
        return r;
    endfunction

    task automatic clear_model();
        for (int t = 0; t < NT; t++) begin
            m_conn[t] = '0;
            m_used[t] = 1'b0;
        end
    endtask

    task automatic push_check(string tag);
        item_t it;
        it.out_exp  = model_out(sig_in);
        it.used_exp = model_used();
        it.tag      = tag;
        sb_q.push_back(it);
        -> item_ev;
    endtask

    task automatic set_sig(logic [NS-1:0] v, string tag);
        @(negedge clk);
        sig_in = v;
        push_check(tag);
    endtask

    // Checks the old map before the edge and the new one after it
    task automatic write_row(int addr, logic [NC-1:0] conn, logic used, string tag);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = addr[5:0];
        wr_conn = conn;
        wr_used = used;
        push_check(tag);
        @(negedge clk);
        wr_en = 1'b0;
        m_conn[addr] = conn;
        m_used[addr] = used;
        push_check(tag);
    endtask

    // Monitor: samples 1 ns after each item is pushed, well before the next edge
    initial begin
        forever begin
            @(item_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (term_out !== it.out_exp || term_used !== it.used_exp) begin
                    errors++;
                    $display("FAIL %s term_out=%h exp=%h term_used=%h exp=%h",
                             it.tag, term_out, it.out_exp, term_used, it.used_exp);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        push_check("R1");
        set_sig(16'hFFFF, "R1");

        // R4: enabled empty row is HIGH for any input
        write_row(0, '0, 1'b1, "R4");
        set_sig(16'h0000, "R4");
        set_sig(16'hA5C3, "R4");

        // R2/R3: term 1 uses true column of signal 0 (col 0)
        write_row(1, 32'h0000_0001, 1'b1, "R2");
        set_sig(16'h0001, "R2");
        set_sig(16'h0000, "R2");
        // term 2 uses inverted column of signal 3 (col 7)
        write_row(2, 32'h0000_0080, 1'b1, "R2");
        set_sig(16'h0008, "R2");
        set_sig(16'h0000, "R2");
        // term 8 (first of group 1): sig15 high and sig1 low (cols 30, 3)
        write_row(8, 32'h4000_0008, 1'b1, "R3");
        set_sig(16'h8000, "R3");
        set_sig(16'h8002, "R3");
        // term 39: sig15 low (col 31), sig7 high (col 14)
        write_row(39, 32'h8000_4000, 1'b1, "R3");
        set_sig(16'h0080, "R3");

        // R5: term 63 connects both columns of signal 2 (cols 4, 5)
        write_row(63, 32'h0000_0030, 1'b1, "R5");
        set_sig(16'h0004, "R5");
        set_sig(16'h0000, "R5");

        // R6: term 10 has connects but is disabled
        write_row(10, 32'h0000_0001, 1'b0, "R6");
        set_sig(16'h0001, "R6");
        // disabling an active term
        write_row(0, '0, 1'b0, "R6");

        // R7: overwrite a row; pre-edge check sees the old row
        write_row(1, 32'h0000_0002, 1'b1, "R7");
        set_sig(16'h0000, "R7");

        // R3/R8: random inputs, checked between edges
        for (int k = 0; k < 24; k++) begin
            write_row(16 + k, $urandom() & $urandom(), 1'b1, "R3");
        end
        for (int k = 0; k < 30; k++) begin
            set_sig($urandom(), "R8");
        end

        // R1: reset mid run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        push_check("R1");
        set_sig(16'h1234, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule